// File: doc/BRIEF.md
# Calendar Alarm Comparator with Repeat Modes

The block watches a running calendar time (date, hour, minute and second, each a BCD field from an external timekeeping counter) and compares it against a programmed alarm setting once per second. Four repeat bits, one stored beside each alarm field, decide which fields must agree. The choices are a full date-and-time match, a daily, hourly or per-minute repeat, or an alarm on every second. When the selected fields agree on a second tick, an alarm flag is latched. If the interrupt is enabled, that flag pulls an active-low interrupt line.

Software reaches the alarm fields, an enable register and a flag register over a simple byte-wide bus. Reading the flag register clears the flag and releases the interrupt. The read itself still returns the flag as set; a later read shows it cleared. A supply-fail indication puts the block in backup mode. In backup mode the bus is ignored and the interrupt may fire only if a second, backup-specific enable is also set. Reset models power-up and clears every register, both enables included.

Top module: `cal_alarm`

## Requirements
- R1: After reset the flag, both enables, all alarm fields and repeat bits and the read data are 0, and irq_no is high.
- R2: The register map is as follows. Seconds alarm is at 0x1FF2, minutes at 0x1FF3, hours at 0x1FF4 and date at 0x1FF5, each with its value in bits [6:0] and its repeat bit in bit 7. Those repeat bits are named rpt1 for seconds through rpt4 for date. The enable register is at 0x1FF6, with interrupt enable in bit 7 and backup enable in bit 5. The flag register is at 0x1FF0, with the flag in bit 6. Unmapped addresses read 0. Read data appears on bus_rdata_o one cycle after the read strobe and holds until the next read.
- R3: The flag is set at a clock edge where tick_i is high and the selected fields match, and is visible the cycle after. It is never set at an edge without tick_i.
- R4: The code {rpt4,rpt3,rpt2,rpt1} selects the comparison. 0000 compares all four fields. 1000 ignores the date. 1100 ignores date and hour. 1110 compares only seconds. 1111 matches on every tick.
- R5: Any other repeat code behaves like 1111 and sets the flag on every tick.
- R6: With the date alarm field at 0 and the repeat code 0000, the alarm is disabled and never sets the flag, whatever the current time.
- R7: A read of the flag register returns the flag and clears it, so the next read returns 0. If a new match sets the flag at the same edge as the clearing read, the flag stays set.
- R8: Outside backup mode, irq_no is low exactly when the flag and the interrupt enable are both 1.
- R9: In backup mode the flag still sets on a match, but irq_no goes low only when the flag, the interrupt enable and the backup enable are all 1.
- R10: While backup_i is high, bus accesses have no effect: no register changes, the flag is not cleared and the read data holds.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset (power-up) |
| tick_i | input | 1 | One-cycle pulse once per second |
| sec_i | input | 7 | Current seconds, BCD |
| min_i | input | 7 | Current minutes, BCD |
| hour_i | input | 7 | Current hours, BCD |
| date_i | input | 7 | Current day of month, BCD |
| backup_i | input | 1 | High while running from backup supply |
| bus_sel_i | input | 1 | Bus access strobe |
| bus_we_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 13 | Byte address |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Registered read data |
| irq_no | output | 1 | Active-low alarm interrupt |

## Verification
Each result has a fixed latency. A match or a clearing read changes the flag at the edge where the stimulus is sampled. Because irq_no is derived combinationally from the flag and the enables, it changes in the same cycle the flag changes. Read data is registered and shows the pre-clear flag one cycle after the strobe. The bench applies every stimulus at a falling edge and advances a behavioural model at the rising edge. It then compares irq_no and bus_rdata_o at the next falling edge, so each due cycle is checked exactly once and no race with the clock edge arises.

// File: rtl/cal_alarm_pkg.sv
package cal_alarm_pkg;
  localparam int NFLD   = 4;   // sec, min, hour, date
  localparam int DATA_W = 8;

  localparam int F_SEC  = 0;
  localparam int F_MIN  = 1;
  localparam int F_HOUR = 2;
  localparam int F_DATE = 3;

  // {rpt4,rpt3,rpt2,rpt1}: bit i set masks field i
  typedef enum logic [NFLD-1:0] {
    RPT_FULL = 4'b0000,
    RPT_DAY  = 4'b1000,
    RPT_HOUR = 4'b1100,
    RPT_MIN  = 4'b1110,
    RPT_SEC  = 4'b1111
  } rpt_e;

  function automatic logic [NFLD-1:0] eff_mask(input logic [NFLD-1:0] code);
    case (code)
      RPT_FULL, RPT_DAY, RPT_HOUR, RPT_MIN, RPT_SEC: eff_mask = code;
      default:                                       eff_mask = RPT_SEC;
    endcase
  endfunction
endpackage

// File: rtl/cal_alarm_regs.sv
module cal_alarm_regs
  import cal_alarm_pkg::*;
#(
  parameter int ADDR_W  = 13,
  parameter int FIELD_W = 7,
  parameter logic [ADDR_W-1:0] FLAG_ADDR = 13'h1FF0,
  parameter logic [ADDR_W-1:0] ALM_BASE  = 13'h1FF2,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 13'h1FF6,
  parameter int AF_BIT  = 6,
  parameter int AFE_BIT = 7,
  parameter int ABE_BIT = 5
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           acc_i,
  input  logic                           we_i,
  input  logic [ADDR_W-1:0]              addr_i,
  input  logic [DATA_W-1:0]              wdata_i,
  input  logic                           af_i,
  output logic [NFLD-1:0][FIELD_W-1:0]   alm_o,
  output logic [NFLD-1:0]                rpt_o,
  output logic                           afe_o,
  output logic                           abe_o,
  output logic [DATA_W-1:0]              rdata_o,
  output logic                           flag_rd_o
);
  localparam int RPT_BIT = DATA_W - 1;

  logic            wr;
  logic            rd;
  logic [DATA_W-1:0] rd_val;

  assign wr = acc_i & we_i;
  assign rd = acc_i & ~we_i;

  for (genvar i = 0; i < NFLD; i++) begin : g_fld
    localparam logic [ADDR_W-1:0] FADDR = ADDR_W'(ALM_BASE + ADDR_W'(i));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        alm_o[i] <= '0;
        rpt_o[i] <= 1'b0;
      end else if (wr && addr_i == FADDR) begin
        alm_o[i] <= wdata_i[FIELD_W-1:0];
        rpt_o[i] <= wdata_i[RPT_BIT];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      afe_o <= 1'b0;
      abe_o <= 1'b0;
    end else if (wr && addr_i == CTRL_ADDR) begin
      afe_o <= wdata_i[AFE_BIT];
      abe_o <= wdata_i[ABE_BIT];
    end
  end

  always_comb begin
    rd_val = '0;
    if (addr_i == FLAG_ADDR) rd_val[AF_BIT] = af_i;
    if (addr_i == CTRL_ADDR) begin
      rd_val[AFE_BIT] = afe_o;
      rd_val[ABE_BIT] = abe_o;
    end
    for (int i = 0; i < NFLD; i++) begin
      if (addr_i == ADDR_W'(ALM_BASE + ADDR_W'(i))) begin
        rd_val[FIELD_W-1:0] = alm_o[i];
        rd_val[RPT_BIT]     = rpt_o[i];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)  rdata_o <= '0;
    else if (rd)  rdata_o <= rd_val;
  end

  assign flag_rd_o = rd && addr_i == FLAG_ADDR;
endmodule

// File: rtl/cal_alarm_match.sv
module cal_alarm_match
  import cal_alarm_pkg::*;
#(
  parameter int FIELD_W = 7
) (
  input  logic [NFLD-1:0][FIELD_W-1:0] cur_i,
  input  logic [NFLD-1:0][FIELD_W-1:0] alm_i,
  input  logic [NFLD-1:0]              rpt_i,
  output logic                         hit_o
);
  logic [NFLD-1:0] mask;
  logic [NFLD-1:0] fld_ok;
  logic            off;

  assign mask = eff_mask(rpt_i);

  for (genvar i = 0; i < NFLD; i++) begin : g_cmp
    assign fld_ok[i] = mask[i] | (cur_i[i] == alm_i[i]);
  end

  // zero date with full-match code switches the alarm off
  assign off   = (rpt_i == RPT_FULL) && (alm_i[F_DATE] == '0);
  assign hit_o = (&fld_ok) & ~off;
endmodule

// File: rtl/cal_alarm_flag.sv
module cal_alarm_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic hit_i,
  input  logic clr_i,
  input  logic afe_i,
  input  logic abe_i,
  input  logic backup_i,
  output logic af_o,
  output logic irq_no
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              af_o <= 1'b0;
    else if (tick_i && hit_i) af_o <= 1'b1;   // new event beats clear
    else if (clr_i)           af_o <= 1'b0;
  end

  assign irq_no = ~(af_o & afe_i & (~backup_i | abe_i));
endmodule

// File: rtl/cal_alarm.sv
module cal_alarm
  import cal_alarm_pkg::*;
#(
  parameter int ADDR_W  = 13,
  parameter int FIELD_W = 7,
  parameter logic [ADDR_W-1:0] FLAG_ADDR = 13'h1FF0,
  parameter logic [ADDR_W-1:0] ALM_BASE  = 13'h1FF2,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 13'h1FF6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic [FIELD_W-1:0] sec_i,
  input  logic [FIELD_W-1:0] min_i,
  input  logic [FIELD_W-1:0] hour_i,
  input  logic [FIELD_W-1:0] date_i,
  input  logic              backup_i,
  input  logic              bus_sel_i,
  input  logic              bus_we_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  output logic [DATA_W-1:0] bus_rdata_o,
  output logic              irq_no
);
  logic [NFLD-1:0][FIELD_W-1:0] cur;
  logic [NFLD-1:0][FIELD_W-1:0] alm;
  logic [NFLD-1:0]              rpt;
  logic acc, afe_w, abe_w, af_w, hit, flag_rd;

  assign cur[F_SEC]  = sec_i;
  assign cur[F_MIN]  = min_i;
  assign cur[F_HOUR] = hour_i;
  assign cur[F_DATE] = date_i;
  assign acc = bus_sel_i & ~backup_i;

  cal_alarm_regs #(
    .ADDR_W(ADDR_W), .FIELD_W(FIELD_W),
    .FLAG_ADDR(FLAG_ADDR), .ALM_BASE(ALM_BASE), .CTRL_ADDR(CTRL_ADDR)
  ) u_regs (
    .clk_i(clk_i), .rst_ni(rst_ni), .acc_i(acc), .we_i(bus_we_i),
    .addr_i(bus_addr_i), .wdata_i(bus_wdata_i), .af_i(af_w),
    .alm_o(alm), .rpt_o(rpt), .afe_o(afe_w), .abe_o(abe_w),
    .rdata_o(bus_rdata_o), .flag_rd_o(flag_rd)
  );

  cal_alarm_match #(.FIELD_W(FIELD_W)) u_match (
    .cur_i(cur), .alm_i(alm), .rpt_i(rpt), .hit_o(hit)
  );

  cal_alarm_flag u_flag (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_i), .hit_i(hit),
    .clr_i(flag_rd), .afe_i(afe_w), .abe_i(abe_w), .backup_i(backup_i),
    .af_o(af_w), .irq_no(irq_no)
  );
endmodule

// File: rtl/cal_alarm_chk.sv
module cal_alarm_chk #(
  parameter int ADDR_W = 13,
  parameter logic [ADDR_W-1:0] FLAG_ADDR = 13'h1FF0
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              tick_i,
  input logic              backup_i,
  input logic              bus_sel_i,
  input logic              bus_we_i,
  input logic [ADDR_W-1:0] bus_addr_i,
  input logic [7:0]        bus_rdata_o,
  input logic              irq_no,
  input logic              af,
  input logic              afe,
  input logic              abe
);
  logic flag_rd;
  assign flag_rd = bus_sel_i && !bus_we_i && !backup_i && bus_addr_i == FLAG_ADDR;

  // R3
  af_needs_tick_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(af) |-> $past(tick_i));

  // R7
  rd_clears_af_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_rd && !tick_i) |=> !af);

  // R2
  rd_shows_af_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flag_rd |=> bus_rdata_o[6] == $past(af));

  // R8
  irq_needs_af_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !irq_no |-> (af && afe));

  // R9
  backup_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (backup_i && !abe) |-> irq_no);

  // R10
  backup_bus_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (backup_i && bus_sel_i) |=> ($stable(afe) && $stable(abe) && $stable(bus_rdata_o)));
endmodule

bind cal_alarm cal_alarm_chk #(.ADDR_W(ADDR_W), .FLAG_ADDR(FLAG_ADDR)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_i), .backup_i(backup_i),
  .bus_sel_i(bus_sel_i), .bus_we_i(bus_we_i), .bus_addr_i(bus_addr_i),
  .bus_rdata_o(bus_rdata_o), .irq_no(irq_no),
  .af(af_w), .afe(afe_w), .abe(abe_w)
);

// File: tb/sim_cal_alarm.sv
module sim_cal_alarm;
  logic clk = 1'b0, rst_ni = 1'b0, tick = 1'b0, backup = 1'b0;
  logic [6:0] sec = '0, mnt = '0, hr = '0, dt = '0;
  logic sel = 1'b0, we = 1'b0;
  logic [12:0] addr = '0;
  logic [7:0]  wdata = '0;
  logic [7:0]  rdata;
  logic        irq_n;

  always #10 clk = ~clk;

  cal_alarm u0 (
    .clk_i(clk), .rst_ni(rst_ni), .tick_i(tick), .sec_i(sec), .min_i(mnt),
    .hour_i(hr), .date_i(dt), .backup_i(backup), .bus_sel_i(sel),
    .bus_we_i(we), .bus_addr_i(addr), .bus_wdata_i(wdata),
    .bus_rdata_o(rdata), .irq_no(irq_n)
  );

  // behavioural reference
  int   m_val [4];
  int   m_rpt [4];
  bit   m_afe, m_abe, m_af;
  int   m_rd;
  int   n_chk = 0, n_fail = 0;
  string req = "R1";
  bit   done = 0;

  function automatic bit model_hit();
    int cur [4];
    int depth;   // how many fields from seconds upward are compared
    int code;
    cur[0] = sec; cur[1] = mnt; cur[2] = hr; cur[3] = dt;
    code = m_rpt[3]*8 + m_rpt[2]*4 + m_rpt[1]*2 + m_rpt[0];
    if (code == 0 && m_val[3] == 0) return 0;
    if (code == 0)       depth = 4;
    else if (code == 8)  depth = 3;
    else if (code == 12) depth = 2;
    else if (code == 14) depth = 1;
    else                 depth = 0;
    for (int i = 0; i < depth; i++) if (cur[i] != m_val[i]) return 0;
    return 1;
  endfunction

  function automatic int model_read(int a);
    if (a == 'h1FF0) return m_af ? 'h40 : 0;
    if (a == 'h1FF6) return (m_afe ? 'h80 : 0) + (m_abe ? 'h20 : 0);
    if (a >= 'h1FF2 && a <= 'h1FF5) return m_rpt[a-'h1FF2]*128 + m_val[a-'h1FF2];
    return 0;
  endfunction

  task automatic model_reset();
    for (int i = 0; i < 4; i++) begin m_val[i] = 0; m_rpt[i] = 0; end
    m_afe = 0; m_abe = 0; m_af = 0; m_rd = 0;
  endtask

  task automatic step();
    bit clr, set;
    @(posedge clk);
    if (!rst_ni) model_reset();
    else begin
      clr = 0;
      set = tick && model_hit();
      if (sel && !backup) begin
        if (we) begin
          if (addr >= 'h1FF2 && addr <= 'h1FF5) begin
            m_val[addr-'h1FF2] = wdata % 128;
            m_rpt[addr-'h1FF2] = wdata / 128;
          end else if (addr == 'h1FF6) begin
            m_afe = wdata[7]; m_abe = wdata[5];
          end
        end else begin
          m_rd = model_read(addr);
          clr  = (addr == 'h1FF0);
        end
      end
      if (set) m_af = 1; else if (clr) m_af = 0;
    end
    @(negedge clk);
    begin
      bit exp_irq;
      exp_irq = !(m_af && m_afe && (!backup || m_abe));
      n_chk++;
      if (irq_n !== exp_irq) begin
        n_fail++;
        $display("FAIL %s irq_no actual=%b expected=%b", req, irq_n, exp_irq);
      end
      n_chk++;
      if (rdata !== 8'(m_rd)) begin
        n_fail++;
        $display("FAIL %s rdata actual=%h expected=%h", req, rdata, 8'(m_rd));
      end
    end
  endtask

  task automatic wr(int a, int d);
    sel = 1; we = 1; addr = 13'(a); wdata = 8'(d);
    step();
    sel = 0; we = 0;
  endtask

  task automatic rd(int a);
    sel = 1; we = 0; addr = 13'(a);
    step();
    sel = 0;
  endtask

  task automatic tk();
    tick = 1; step(); tick = 0;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic set_time(int d, int h, int m, int s);
    dt = 7'(d); hr = 7'(h); mnt = 7'(m); sec = 7'(s);
  endtask

  task automatic set_alarm(int code, int d, int h, int m, int s);
    wr('h1FF2, ((code >> 0) & 1) * 128 + s);
    wr('h1FF3, ((code >> 1) & 1) * 128 + m);
    wr('h1FF4, ((code >> 2) & 1) * 128 + h);
    wr('h1FF5, ((code >> 3) & 1) * 128 + d);
  endtask

  initial begin
    model_reset();
    @(negedge clk);
    req = "R1"; step(); step();
    rst_ni = 1; idle(2);

    req = "R2";
    set_alarm(0, 'h15, 'h10, 'h30, 'h45);
    for (int a = 'h1FF0; a <= 'h1FF7; a++) rd(a);
    wr('h1FF6, 'hA0); rd('h1FF6); wr('h1FF6, 0); rd('h1FF6);

    req = "R3"; set_time('h15, 'h10, 'h30, 'h45);
    idle(3); rd('h1FF0);
    tk(); rd('h1FF0);
    req = "R7"; rd('h1FF0); rd('h1FF0);

    req = "R8"; wr('h1FF6, 'h80); tk(); idle(2); rd('h1FF0); idle(1);
    wr('h1FF6, 0); tk(); idle(1); rd('h1FF0);
    wr('h1FF6, 'h80);

    req = "R4";
    set_time('h16, 'h10, 'h30, 'h45); tk(); rd('h1FF0);
    set_alarm('b1000, 'h15, 'h10, 'h30, 'h45); tk(); rd('h1FF0);
    set_time('h16, 'h11, 'h30, 'h45); tk(); rd('h1FF0);
    set_alarm('b1100, 'h15, 'h10, 'h30, 'h45); tk(); rd('h1FF0);
    set_time('h16, 'h11, 'h31, 'h45); tk(); rd('h1FF0);
    set_alarm('b1110, 'h15, 'h10, 'h30, 'h45); tk(); rd('h1FF0);
    set_time('h16, 'h11, 'h31, 'h46); tk(); rd('h1FF0);
    set_alarm('b1111, 'h15, 'h10, 'h30, 'h45); tk(); rd('h1FF0); tk(); rd('h1FF0);

    req = "R5";
    for (int c = 1; c < 16; c++) begin
      if (c == 8 || c == 12 || c == 14 || c == 15) continue;
      set_alarm(c, 'h01, 'h02, 'h03, 'h04);
      tk(); rd('h1FF0);
    end

    req = "R6";
    set_alarm(0, 0, 'h11, 'h31, 'h46); set_time(0, 'h11, 'h31, 'h46);
    tk(); rd('h1FF0); set_time('h16, 'h11, 'h31, 'h46); tk(); rd('h1FF0);

    req = "R7"; set_alarm('b1111, 1, 1, 1, 1);
    tk(); sel = 1; we = 0; addr = 13'h1FF0; tick = 1; step(); sel = 0; tick = 0;
    rd('h1FF0); rd('h1FF0);

    req = "R9"; wr('h1FF6, 'h80); backup = 1;
    tk(); idle(2); backup = 0; step(); backup = 1;
    req = "R10"; wr('h1FF6, 'h00); rd('h1FF0); idle(1);
    backup = 0; rd('h1FF6); rd('h1FF0);
    req = "R9"; wr('h1FF6, 'hA0); backup = 1; tk(); idle(2);
    backup = 0; rd('h1FF0);

    req = "R1"; wr('h1FF6, 'hA0); tk(); rst_ni = 0; step(); rst_ni = 1;
    rd('h1FF6); rd('h1FF2); rd('h1FF0); tk(); rd('h1FF0);

    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule